// File: doc/BRIEF.md
# Repeater Port Auto-Partition Controller

This block sits between the receive side of each repeater port and the shared repeater core. For every port it watches two qualified inputs, "activity present" and "collision present", and decides whether the core may see them. A port that keeps colliding, or that holds a collision far too long, is isolated: the core then sees that port as silent and collision-free. The port is not taken out of the network. The block keeps watching it, and once the port carries one clean transmission of sufficient length, it is let back in.

Each port has its own eight-state machine. Each also has a consecutive-collision counter, a clean-window timer and a long-collision timer. Both timers advance only on a bit-time tick, so they measure bit times at 10 Mb/s whatever the fabric clock is. The number of ports, the collision limit and both timer lengths are parameters. Their defaults are 4 ports, 64 collisions, a 512 bit-time clean window and a 1024 bit-time long-collision limit. All outputs are registered and follow the inputs by one clock.

Top module: `ap_partition_ctrl`

## Requirements
- R1: While `rst` is high and on the first clock after it, `data_o`, `coll_o` and `isolated_o` are all 0 for every port, and the collision count of every port is 0.
- R2: For a port that is not isolated, `data_o[p]` and `coll_o[p]` equal `act_i[p]` and `coll_i[p]` as sampled on the previous rising clock edge.
- R3: A collision counts once, when it begins after activity has started from idle. On the 64th collision without an intervening clear, the port becomes isolated. After 63 collisions it is still connected.
- R4: While `isolated_o[p]` is 1, `data_o[p]` and `coll_o[p]` are 0, whatever the port's inputs are.
- R5: If one collision stays present for more than 1024 bit ticks after it was counted, the port is isolated. A collision of 900 ticks is not enough.
- R6: A transmission that lasts 512 bit ticks without a collision clears the collision count. A clean transmission of 300 ticks leaves the count unchanged.
- R7: An isolated port is reconnected only on the first idle clock after a clean transmission of at least 512 bit ticks, and it stays isolated until that idle arrives. Shorter bursts do not reconnect it. A collision during that final transmission sends it back to isolated waiting. After reconnection the count is 0.
- R8: Both timers advance only on clocks where `bit_tick_i` is 1. With the tick held low, no length of clean transmission reconnects the port.
- R9: If a collision is present on the same clock on which the clean window expires, the collision takes priority: it is counted, and the count is not cleared.
- R10: Ports are independent. Isolating one port does not change the outputs of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick_i | input | 1 | One-clock pulse per bit time |
| act_i | input | NPORTS | Per-port receive activity present |
| coll_i | input | NPORTS | Per-port collision present |
| data_o | output | NPORTS | Activity as passed to the core |
| coll_o | output | NPORTS | Collision as passed to the core |
| isolated_o | output | NPORTS | Port currently partitioned |

## Verification
The clean-window expiry and the start of a collision can land on the same clock. In that case the machine must pick between clearing the count and incrementing it. The bench counts edges from the start of activity and raises the collision exactly on the clock where the 512-tick window completes, with 63 collisions already recorded. The port must then isolate. A control run, with the collision one clock later, must leave the port connected, because by then the window has already cleared the count.

// File: rtl/ap_pkg.sv
package ap_pkg;

  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_WATCH,
    ST_INCR,
    ST_ISO_WAIT,
    ST_ISO_HOLD,
    ST_ISO_WATCH,
    ST_RESTORE
  } ap_state_e;

  function automatic logic ap_is_isolated(input ap_state_e s);
    return (s == ST_ISO_WAIT) || (s == ST_ISO_HOLD) ||
           (s == ST_ISO_WATCH) || (s == ST_RESTORE);
  endfunction

endpackage

// File: rtl/ap_bit_timer.sv
module ap_bit_timer #(
  parameter int LEN = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LEN);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (tick_i && cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = armed_q && (cnt_q == LIMIT);
endmodule

// File: rtl/ap_port_fsm.sv
module ap_port_fsm
  import ap_pkg::*;
#(
  parameter int CC_LIMIT = 64,
  parameter int TW5      = 512,
  parameter int TW6      = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic act_i,
  input  logic coll_i,
  output logic data_o,
  output logic coll_o,
  output logic isolated_o
);
  localparam int CCW = $clog2(CC_LIMIT + 1);
  localparam logic [CCW-1:0] CC_MAX = CCW'(CC_LIMIT);

  ap_state_e      st_q, st_d;
  logic [CCW-1:0] cc_q, cc_d;
  logic           win_start, win_done, long_start, long_done;
  logic           quiet;

  assign quiet = !act_i && !coll_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_CLEAR:     if (quiet) st_d = ST_IDLE;
      ST_IDLE:      if (!quiet) st_d = ST_WATCH;
      ST_WATCH: begin
        if (coll_i)        st_d = ST_INCR;
        else if (win_done) st_d = ST_CLEAR;
        else if (!act_i)   st_d = ST_IDLE;
      end
      ST_INCR: begin
        if (cc_q >= CC_MAX)            st_d = ST_ISO_WAIT;
        else if (coll_i && long_done)  st_d = ST_ISO_WAIT;
        else if (quiet)                st_d = ST_IDLE;
      end
      ST_ISO_WAIT:  if (quiet) st_d = ST_ISO_HOLD;
      ST_ISO_HOLD:  if (!quiet) st_d = ST_ISO_WATCH;
      ST_ISO_WATCH: begin
        if (coll_i)        st_d = ST_ISO_WAIT;
        else if (win_done) st_d = ST_RESTORE;
        else if (!act_i)   st_d = ST_ISO_HOLD;
      end
      ST_RESTORE: begin
        if (coll_i)     st_d = ST_ISO_WAIT;
        else if (quiet) st_d = ST_IDLE;
      end
      default:          st_d = ST_CLEAR;
    endcase
  end

  assign win_start  = ((st_d == ST_WATCH) && (st_q != ST_WATCH)) ||
                      ((st_d == ST_ISO_WATCH) && (st_q != ST_ISO_WATCH));
  assign long_start = (st_d == ST_INCR) && (st_q != ST_INCR);

  always_comb begin
    cc_d = cc_q;
    if (st_d == ST_CLEAR || st_d == ST_RESTORE) cc_d = '0;
    else if (long_start && cc_q != CC_MAX)      cc_d = cc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_CLEAR;
      cc_q       <= '0;
      data_o     <= 1'b0;
      coll_o     <= 1'b0;
      isolated_o <= 1'b0;
    end else begin
      st_q       <= st_d;
      cc_q       <= cc_d;
      isolated_o <= ap_is_isolated(st_d);
      data_o     <= act_i  && !ap_is_isolated(st_d);
      coll_o     <= coll_i && !ap_is_isolated(st_d);
    end
  end

  ap_bit_timer #(.LEN(TW5)) u_win (
    .clk(clk), .rst(rst), .start_i(win_start), .tick_i(tick_i), .done_o(win_done)
  );

  ap_bit_timer #(.LEN(TW6)) u_long (
    .clk(clk), .rst(rst), .start_i(long_start), .tick_i(tick_i), .done_o(long_done)
  );
endmodule

// File: rtl/ap_partition_ctrl.sv
module ap_partition_ctrl #(
  parameter int NPORTS   = 4,
  parameter int CC_LIMIT = 64,
  parameter int TW5      = 512,
  parameter int TW6      = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick_i,
  input  logic [NPORTS-1:0] act_i,
  input  logic [NPORTS-1:0] coll_i,
  output logic [NPORTS-1:0] data_o,
  output logic [NPORTS-1:0] coll_o,
  output logic [NPORTS-1:0] isolated_o
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    ap_port_fsm #(
      .CC_LIMIT(CC_LIMIT), .TW5(TW5), .TW6(TW6)
    ) u_fsm (
      .clk(clk),
      .rst(rst),
      .tick_i(bit_tick_i),
      .act_i(act_i[p]),
      .coll_i(coll_i[p]),
      .data_o(data_o[p]),
      .coll_o(coll_o[p]),
      .isolated_o(isolated_o[p])
    );
  end
endmodule

// File: rtl/ap_partition_chk.sv
module ap_partition_chk #(
  parameter int NPORTS = 4,
  parameter int TW5    = 512
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_tick_i,
  input logic [NPORTS-1:0] act_i,
  input logic [NPORTS-1:0] coll_i,
  input logic [NPORTS-1:0] data_o,
  input logic [NPORTS-1:0] coll_o,
  input logic [NPORTS-1:0] isolated_o
);
  localparam int RW = $clog2(TW5 + 2);
  localparam logic [RW-1:0] RMAX = RW'(TW5 + 1);

  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    logic [RW-1:0] run_q;
    always_ff @(posedge clk) begin
      if (rst || coll_i[p] || !isolated_o[p] || !act_i[p]) run_q <= '0;
      else if (bit_tick_i && run_q != RMAX)                run_q <= run_q + 1'b1;
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
      rst |=> (!data_o[p] && !coll_o[p] && !isolated_o[p]));

    // R4
    a_r4_gated: assert property (@(posedge clk) disable iff (rst)
      isolated_o[p] |-> (!data_o[p] && !coll_o[p]));

    // R2
    a_r2_pass: assert property (@(posedge clk) disable iff (rst)
      (seen_q && !isolated_o[p]) |->
        (data_o[p] == $past(act_i[p]) && coll_o[p] == $past(coll_i[p])));

    // R7
    a_r7_restore_idle: assert property (@(posedge clk) disable iff (rst)
      (seen_q && $fell(isolated_o[p])) |-> $past(!act_i[p] && !coll_i[p]));

    // R7
    a_r7_clean_window: assert property (@(posedge clk) disable iff (rst)
      (seen_q && $fell(isolated_o[p])) |-> ($past(run_q) >= RW'(TW5)));
  end
endmodule

bind ap_partition_ctrl ap_partition_chk #(.NPORTS(NPORTS), .TW5(TW5)) u_chk (
  .clk(clk), .rst(rst), .bit_tick_i(bit_tick_i), .act_i(act_i), .coll_i(coll_i),
  .data_o(data_o), .coll_o(coll_o), .isolated_o(isolated_o)
);

// File: tb/sim_ap_partition_ctrl.sv
`timescale 1ns/1ps
module sim_ap_partition_ctrl;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b1;
  logic [NP-1:0] act = '0;
  logic [NP-1:0] col = '0;
  logic [NP-1:0] d_o, c_o, iso_o;

  always #2.5 clk = ~clk;

  ap_partition_ctrl #(.NPORTS(NP)) u0 (
    .clk(clk), .rst(rst), .bit_tick_i(tick), .act_i(act), .coll_i(col),
    .data_o(d_o), .coll_o(c_o), .isolated_o(iso_o)
  );

  typedef struct {
    int    p;
    logic  d;
    logic  c;
    logic  iso;
    string tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 0;

  // monitor: compares one clock after the item was queued
  always @(posedge clk) begin
    item_t it;
    #1;
    while (q.size() > 0) begin
      it = q.pop_front();
      n_cmp++;
      if (d_o[it.p] !== it.d || c_o[it.p] !== it.c || iso_o[it.p] !== it.iso) begin
        n_bad++;
        $display("FAIL %s port %0d: got data=%b coll=%b iso=%b expected data=%b coll=%b iso=%b",
                 it.tag, it.p, d_o[it.p], c_o[it.p], iso_o[it.p], it.d, it.c, it.iso);
      end
    end
  end

  task automatic drv(int p, logic a, logic c);
    @(negedge clk);
    act[p] = a;
    col[p] = c;
  endtask

  task automatic expect_now(int p, logic d, logic c, logic iso, string tag);
    item_t it;
    it.p = p; it.d = d; it.c = c; it.iso = iso; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic coll(int p, int len);
    drv(p, 1'b1, 1'b1);
    repeat (len - 1) @(negedge clk);
    drv(p, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic colls(int p, int n);
    for (int k = 0; k < n; k++) coll(p, 3);
  endtask

  task automatic burst(int p, int len);
    drv(p, 1'b1, 1'b0);
    repeat (len - 1) @(negedge clk);
    drv(p, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got no end of run, expected end within 200000 cycles");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    expect_now(0, 1'b0, 1'b0, 1'b0, "R1 during reset");
    rst = 1'b0;
    expect_now(1, 1'b0, 1'b0, 1'b0, "R1 after reset");

    // R2 pass-through
    drv(0, 1'b1, 1'b0); expect_now(0, 1'b1, 1'b0, 1'b0, "R2 data");
    drv(0, 1'b1, 1'b1); expect_now(0, 1'b1, 1'b1, 1'b0, "R2 coll");
    drv(0, 1'b0, 1'b0); expect_now(0, 1'b0, 1'b0, 1'b0, "R2 idle");
    @(negedge clk); rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);

    // R3 limit
    colls(0, 63);
    expect_now(0, 1'b0, 1'b0, 1'b0, "R3 63 collisions");
    coll(0, 3);
    expect_now(0, 1'b0, 1'b0, 1'b1, "R3 64th collision");

    // R4 gating
    drv(0, 1'b1, 1'b1); expect_now(0, 1'b0, 1'b0, 1'b1, "R4 coll gated");
    drv(0, 1'b1, 1'b0); expect_now(0, 1'b0, 1'b0, 1'b1, "R4 data gated");
    drv(0, 1'b0, 1'b0); repeat (3) @(negedge clk);

    // R10 independence
    drv(1, 1'b1, 1'b0); expect_now(1, 1'b1, 1'b0, 1'b0, "R10 other port passes");
    drv(1, 1'b0, 1'b0); expect_now(0, 1'b0, 1'b0, 1'b1, "R10 isolated port kept");

    // R7 reconnection
    burst(0, 300);
    expect_now(0, 1'b0, 1'b0, 1'b1, "R7 short burst");
    drv(0, 1'b1, 1'b0); repeat (599) @(negedge clk);
    drv(0, 1'b1, 1'b1); expect_now(0, 1'b0, 1'b0, 1'b1, "R7 coll in restore");
    drv(0, 1'b0, 1'b0); repeat (3) @(negedge clk);
    expect_now(0, 1'b0, 1'b0, 1'b1, "R7 back to waiting");
    drv(0, 1'b1, 1'b0); repeat (598) @(negedge clk);
    expect_now(0, 1'b0, 1'b0, 1'b1, "R7 held until idle");
    drv(0, 1'b0, 1'b0); expect_now(0, 1'b0, 1'b0, 1'b0, "R7 reconnect on idle");
    repeat (3) @(negedge clk);
    colls(0, 63);
    expect_now(0, 1'b0, 1'b0, 1'b0, "R7 count zero after reconnect");
    coll(0, 3);
    expect_now(0, 1'b0, 1'b0, 1'b1, "R3 isolate again");

    // R8 tick gating
    tick = 1'b0;
    burst(0, 800);
    expect_now(0, 1'b0, 1'b0, 1'b1, "R8 no tick no reconnect");
    tick = 1'b1;
    burst(0, 600);
    expect_now(0, 1'b0, 1'b0, 1'b0, "R8 reconnect with tick");

    // R6 clean window
    colls(0, 63);
    burst(0, 300);
    coll(0, 3);
    expect_now(0, 1'b0, 1'b0, 1'b1, "R6 short clean keeps count");
    burst(0, 600);
    colls(0, 63);
    burst(0, 600);
    colls(0, 63);
    expect_now(0, 1'b0, 1'b0, 1'b0, "R6 long clean clears count");
    burst(0, 600);

    // R5 long collision
    coll(0, 900);
    expect_now(0, 1'b0, 1'b0, 1'b0, "R5 900 tick collision");
    burst(0, 600);
    coll(0, 1100);
    expect_now(0, 1'b0, 1'b0, 1'b1, "R5 1100 tick collision");
    burst(0, 600);
    expect_now(0, 1'b0, 1'b0, 0, "R7 reconnect after long");

    // R9 control: collision one clock after window expiry
    colls(0, 63);
    @(negedge clk); act[0] = 1'b1;
    repeat (514) @(posedge clk);
    @(negedge clk); col[0] = 1'b1;
    repeat (2) @(negedge clk);
    act[0] = 1'b0; col[0] = 1'b0;
    repeat (3) @(negedge clk);
    coll(0, 3);
    expect_now(0, 1'b0, 1'b0, 1'b0, "R9 window expired first");
    // R9 same clock: collision wins
    colls(0, 62);
    @(negedge clk); act[0] = 1'b1;
    repeat (513) @(posedge clk);
    @(negedge clk); col[0] = 1'b1;
    repeat (2) @(negedge clk);
    act[0] = 1'b0; col[0] = 1'b0;
    repeat (3) @(negedge clk);
    expect_now(0, 1'b0, 1'b0, 1'b1, "R9 collision on expiry counted");

    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    ended = 1;
    finish_run();
  end
endmodule